// File: doc/BRIEF.md
# CAN Bit Timing and Sampling Unit

This block cuts each CAN bit into time quanta and three segments: a one-quantum synchronization segment, a first phase segment that ends at the sample point, and a second phase segment that ends at the transmit point. The transmit point is also where the next bit begins. A protocol engine above it takes the sampled bit value, the transmit-point strobe and the quantum tick. The frame layer stays outside this block.

The receive input is already synchronized to the module clock. A logic 1 on it is recessive and a logic 0 is dominant. While the bus is idle and the hard-sync enable is set, a recessive-to-dominant edge restarts the bit. During a frame the same edge resynchronizes the bit instead. A late edge stretches the first segment and an early edge shortens the second, and the correction is capped by the jump width. Majority voting over three samples can be selected instead of a single sample.

Every timing field is programmed as its count minus one:
- `prescale_m1` + 1 gives the clocks per quantum.
- `tseg1_m1` + 1 gives the first segment length, from 1 to 16 quanta.
- `tseg2_m1` + 1 gives the second segment length, from 1 to 8 quanta.
- `sjw_m1` + 1 gives the jump width, from 1 to 4 quanta.

Top module: `can_bit_timing`

## Requirements
- R1: `tq_tick` pulses for one clock in the last clock of every quantum, so it repeats every `prescale_m1`+1 clocks. A hard sync restarts the quantum, so the first tick after it comes `prescale_m1`+1 clocks after the edge cycle.
- R2: Without edges, a bit lasts 1 + (`tseg1_m1`+1) + (`tseg2_m1`+1) quanta. `tx_point` is a one-clock pulse in the last clock of the bit, and the synchronization segment starts in the next clock.
- R3: The sample point is the last clock of the first segment. `sample_valid` pulses one clock after it, with `sample_bit` holding the sampled value.
- R4: When `idle_sync_en` is 1, a falling edge on `rx_bit` (1 followed by 0) in any cycle makes the synchronization segment start in the next clock.
- R5: When `idle_sync_en` is 0, a falling edge detected in quantum k (counting from 0) of the first segment lengthens that segment by min(k+1, jump width) quanta.
- R6: When `idle_sync_en` is 0, a falling edge detected in quantum q (counting from 0) of the second segment, with length L2, shortens that segment by min(L2−q, jump width) quanta. The segment never ends before the quantum that holds the edge.
- R7: A falling edge in the synchronization segment causes no adjustment. Only the first falling edge of a bit is acted on. Rising edges have no effect.
- R8: A falling edge detected in the sample-point clock itself still lengthens the first segment, and the sample moves later by the added quanta.
- R9: With `triple_en` at 0, `sample_bit` is `rx_bit` in the sample-point clock. With `triple_en` at 1, `sample_bit` is the majority of `rx_bit` in that clock and the two clocks before it, which is meaningful when the prescaler is at least 3.
- R10: While `rst_n` is low, `sample_valid`, `tx_point` and `tq_tick` are 0 and `sample_bit` is 1. After reset the unit starts at the beginning of the synchronization segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_bit | input | 1 | Synchronized receive line (1 = recessive) |
| prescale_m1 | input | PRESC_W | Clocks per quantum minus one |
| tseg1_m1 | input | TS1_W | First phase segment quanta minus one |
| tseg2_m1 | input | TS2_W | Second phase segment quanta minus one |
| sjw_m1 | input | SJW_W | Jump width quanta minus one |
| triple_en | input | 1 | Select three-sample majority |
| idle_sync_en | input | 1 | Bus idle: falling edges hard-sync |
| sample_bit | output | 1 | Sampled bit value |
| sample_valid | output | 1 | One-clock strobe for `sample_bit` |
| tx_point | output | 1 | One-clock strobe at the end of the bit |
| tq_tick | output | 1 | One-clock strobe at the end of each quantum |

## Verification
A resynchronizing edge and the sample point can fall in the same clock. The bench provokes this by dropping `rx_bit` in exactly the last clock of the first segment. It then expects the sample to move later by the clamped jump width, and not to be taken in that clock. The triple-sample patterns also make a glitch land on the sample clock after the bit has already used its one resynchronization. In that case the bench judges that the glitch changes only the vote and not the timing.

// File: rtl/can_bt_pkg.sv
// Package: shared segment encoding for the CAN bit timing unit.
// Assumes: segments advance in the order SYNC, BS1, BS2.
package can_bt_pkg;
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_BS1  = 2'd1,
        SEG_BS2  = 2'd2
    } seg_e;
endpackage

// File: rtl/tq_prescaler.sv
// Quantum prescaler: divides the module clock into time quanta.
// Assumes: prescale_m1 is static while the bus runs. A restart clears the count.
module tq_prescaler #(
    parameter int PRESC_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] prescale_m1,
    input  logic               restart,
    output logic               tq_tick
);
    logic [PRESC_W-1:0] cnt_q;

    assign tq_tick = (cnt_q >= prescale_m1);

    // Count clocks inside a quantum and wrap at the end of it.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (tq_tick) cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end

    assert_tick_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tq_tick |=> (cnt_q == '0));
endmodule

// File: rtl/bit_segmenter.sv
// Bit segmenter: steps SYNC/BS1/BS2 on quantum ticks, applies hard sync and
// a resync limited by the jump width, and flags the sample and transmit points.
// Assumes: rx_bit is synchronized, 1 = recessive, and the config is static.
module bit_segmenter
    import can_bt_pkg::*;
#(
    parameter int TS1_W = 4,
    parameter int TS2_W = 3,
    parameter int SJW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tq_tick,
    input  logic             rx_bit,
    input  logic [TS1_W-1:0] tseg1_m1,
    input  logic [TS2_W-1:0] tseg2_m1,
    input  logic [SJW_W-1:0] sjw_m1,
    input  logic             idle_sync_en,
    output logic             hard_sync,
    output logic             sample_pt,
    output logic             tx_point
);
    localparam int CW = ((TS1_W > TS2_W) ? TS1_W : TS2_W) + 2;

    seg_e          seg_q;
    logic [CW-1:0] qcnt_q, ext_q, shrink_q;
    logic          rs_done_q, rx_prev_q;

    logic [CW-1:0] sjw_val, len1m1, len2, err1, err2;
    logic [CW-1:0] ext_new, shrink_new, ext_eff, shrink_eff;
    logic          fall, resync_now, bs1_end, bs2_end;

    // Decode the programmed lengths and the phase error of an edge.
    always_comb begin
        sjw_val    = CW'(sjw_m1) + 1'b1;
        len1m1     = CW'(tseg1_m1);
        len2       = CW'(tseg2_m1) + 1'b1;
        err1       = qcnt_q + 1'b1;
        err2       = len2 - qcnt_q;
        ext_new    = (err1 < sjw_val) ? err1 : sjw_val;
        shrink_new = (err2 < sjw_val) ? err2 : sjw_val;
    end

    assign fall       = rx_prev_q & ~rx_bit;
    assign hard_sync  = fall & idle_sync_en;
    assign resync_now = fall & ~idle_sync_en & ~rs_done_q;

    // Apply a correction in the same cycle as the edge so a sample-point edge counts.
    always_comb begin
        ext_eff    = (resync_now && seg_q == SEG_BS1) ? ext_new : ext_q;
        shrink_eff = (resync_now && seg_q == SEG_BS2) ? shrink_new : shrink_q;
        bs1_end    = (seg_q == SEG_BS1) && (qcnt_q >= len1m1 + ext_eff);
        bs2_end    = (seg_q == SEG_BS2) && (qcnt_q + 1'b1 + shrink_eff >= len2);
    end

    assign sample_pt = tq_tick & bs1_end;
    assign tx_point  = tq_tick & bs2_end;

    // Advance the segment state, take sync events and remember corrections.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q     <= SEG_SYNC;
            qcnt_q    <= '0;
            ext_q     <= '0;
            shrink_q  <= '0;
            rs_done_q <= 1'b0;
            rx_prev_q <= 1'b1;
        end else begin
            rx_prev_q <= rx_bit;
            if (hard_sync) begin
                seg_q     <= SEG_SYNC;
                qcnt_q    <= '0;
                ext_q     <= '0;
                shrink_q  <= '0;
                rs_done_q <= 1'b0;
            end else begin
                if (resync_now) begin
                    rs_done_q <= 1'b1;
                    if (seg_q == SEG_BS1) ext_q    <= ext_new;
                    if (seg_q == SEG_BS2) shrink_q <= shrink_new;
                end
                if (tq_tick) begin
                    case (seg_q)
                        SEG_SYNC: begin
                            seg_q  <= SEG_BS1;
                            qcnt_q <= '0;
                        end
                        SEG_BS1: begin
                            if (bs1_end) begin
                                seg_q  <= SEG_BS2;
                                qcnt_q <= '0;
                            end else begin
                                qcnt_q <= qcnt_q + 1'b1;
                            end
                        end
                        SEG_BS2: begin
                            if (bs2_end) begin
                                seg_q     <= SEG_SYNC;
                                qcnt_q    <= '0;
                                ext_q     <= '0;
                                shrink_q  <= '0;
                                rs_done_q <= 1'b0;
                            end else begin
                                qcnt_q <= qcnt_q + 1'b1;
                            end
                        end
                        default: begin
                            seg_q  <= SEG_SYNC;
                            qcnt_q <= '0;
                        end
                    endcase
                end
            end
        end
    end

    assert_tx_then_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_point |=> (seg_q == SEG_SYNC));
    assert_ext_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_q <= sjw_val);
    assert_shrink_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        shrink_q <= sjw_val);
endmodule

// File: rtl/sample_voter.sv
// Sample voter: latches the bus value at the sample point, either as a single
// sample or as the majority of the last three clocks.
// Assumes: the prescaler is at least 3 when triple mode is used.
module sample_voter (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic sample_pt,
    input  logic triple_en,
    output logic sample_bit,
    output logic sample_valid
);
    logic hist1_q, hist2_q, vote;

    assign vote = triple_en ? ((rx_bit & hist1_q) | (rx_bit & hist2_q) | (hist1_q & hist2_q))
                            : rx_bit;

    // Keep a two-clock history of the line and register the voted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist1_q      <= 1'b1;
            hist2_q      <= 1'b1;
            sample_bit   <= 1'b1;
            sample_valid <= 1'b0;
        end else begin
            hist1_q      <= rx_bit;
            hist2_q      <= hist1_q;
            sample_valid <= sample_pt;
            if (sample_pt) sample_bit <= vote;
        end
    end
endmodule

// File: rtl/can_bit_timing.sv
// CAN bit timing top: connects the prescaler, segmenter and voter.
// Assumes: the timing fields hold count-1 and stay stable during a frame.
module can_bit_timing #(
    parameter int PRESC_W = 10,
    parameter int TS1_W   = 4,
    parameter int TS2_W   = 3,
    parameter int SJW_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_bit,
    input  logic [PRESC_W-1:0] prescale_m1,
    input  logic [TS1_W-1:0]   tseg1_m1,
    input  logic [TS2_W-1:0]   tseg2_m1,
    input  logic [SJW_W-1:0]   sjw_m1,
    input  logic               triple_en,
    input  logic               idle_sync_en,
    output logic               sample_bit,
    output logic               sample_valid,
    output logic               tx_point,
    output logic               tq_tick
);
    logic hard_sync, sample_pt;

    tq_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .prescale_m1(prescale_m1),
        .restart(hard_sync), .tq_tick(tq_tick)
    );

    bit_segmenter #(.TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)) u_seg (
        .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .rx_bit(rx_bit),
        .tseg1_m1(tseg1_m1), .tseg2_m1(tseg2_m1), .sjw_m1(sjw_m1),
        .idle_sync_en(idle_sync_en), .hard_sync(hard_sync),
        .sample_pt(sample_pt), .tx_point(tx_point)
    );

    sample_voter u_vote (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .sample_pt(sample_pt),
        .triple_en(triple_en), .sample_bit(sample_bit), .sample_valid(sample_valid)
    );

    assert_sample_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> $past(tq_tick));
endmodule

// File: tb/test_can_bit_timing.sv
module test_can_bit_timing;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit = 1'b1;
    logic [9:0] prescale_m1 = 10'd3;
    logic [3:0] tseg1_m1 = 4'd5;
    logic [2:0] tseg2_m1 = 3'd6;
    logic [1:0] sjw_m1 = 2'd1;
    logic       triple_en = 1'b0;
    logic       idle_sync_en = 1'b0;
    logic       sample_bit, sample_valid, tx_point, tq_tick;

    localparam int P = 4, TS1 = 6;
    int cyc = 0, n_vec = 0, n_bad = 0;

    can_bit_timing i_can_bit_timing (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .prescale_m1(prescale_m1),
        .tseg1_m1(tseg1_m1), .tseg2_m1(tseg2_m1), .sjw_m1(sjw_m1),
        .triple_en(triple_en), .idle_sync_en(idle_sync_en),
        .sample_bit(sample_bit), .sample_valid(sample_valid),
        .tx_point(tx_point), .tq_tick(tq_tick)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Keep rx recessive until a transmit point; return its cycle.
    task automatic wait_tx(output int t);
        t = -1;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk); rx_bit = 1'b1; #1;
            if (tx_point) begin t = cyc; break; end
        end
    endtask

    // Drive up to three rx changes at given cycles until the next transmit point.
    task automatic run_bit(input int c1, input logic v1, input int c2, input logic v2,
                           input int c3, input logic v3,
                           output int sv_c, output logic sv_b, output int tk_c, output int tx_c);
        sv_c = -1; sv_b = 1'bx; tk_c = -1; tx_c = -1;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (cyc == c1) rx_bit = v1;
            if (cyc == c2) rx_bit = v2;
            if (cyc == c3) rx_bit = v3;
            #1;
            if (sample_valid && sv_c < 0) begin sv_c = cyc; sv_b = sample_bit; end
            if (tq_tick && tk_c < 0 && cyc > c1) tk_c = cyc;
            if (tx_point) begin tx_c = cyc; break; end
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        #1;
        check("R10 sample_valid in reset", int'(sample_valid), 0);
        check("R10 tx_point in reset", int'(tx_point), 0);
        check("R10 tq_tick in reset", int'(tq_tick), 0);
        check("R10 sample_bit in reset", int'(sample_bit), 1);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_tick_period;
        int a = -1, b = -1;
        for (int i = 0; i < 40 && b < 0; i++) begin
            @(negedge clk); #1;
            if (tq_tick) begin if (a < 0) a = cyc; else b = cyc; end
        end
        check("R1 quantum tick period", b - a, P);
    endtask

    task automatic t_nominal;
        int t, sc, tk, tx; logic sb;
        wait_tx(t);
        run_bit(-1, 1'b1, -1, 1'b1, -1, 1'b1, sc, sb, tk, tx);
        check("R2 nominal bit length", tx - t, 14 * P);
        check("R3 sample_valid timing", sc, t + 1 + (1 + TS1) * P);
        check("R3 sampled value", int'(sb), 1);
    endtask

    task automatic t_hard_sync;
        int t, c, sc, tk, tx; logic sb;
        wait_tx(t);
        idle_sync_en = 1'b1;
        c = t + 1 + 2 * P + 1;
        run_bit(c, 1'b0, -1, 1'b0, -1, 1'b0, sc, sb, tk, tx);
        idle_sync_en = 1'b0;
        check("R1 tick restarted by hard sync", tk, c + P);
        check("R4 sample after hard sync", sc, c + 1 + (1 + TS1) * P);
        check("R4 bit end after hard sync", tx, c + 14 * P);
    endtask

    // Single falling edge at cycle offset off from bit start; check sample and end.
    task automatic t_edge(input string req, input int off, input int exp_sv, input int exp_tx);
        int t, e0, sc, tk, tx; logic sb;
        wait_tx(t);
        e0 = t + 1;
        run_bit(e0 + off, 1'b0, -1, 1'b0, -1, 1'b0, sc, sb, tk, tx);
        check({req, " sample cycle"}, sc - e0, exp_sv);
        check({req, " bit end cycle"}, tx - e0, exp_tx);
    endtask

    task automatic t_once_per_bit;
        int t, e0, sc, tk, tx; logic sb;
        wait_tx(t);
        e0 = t + 1;
        run_bit(e0 + P + 1, 1'b0, e0 + 2 * P, 1'b1, e0 + 3 * P + 1, 1'b0, sc, sb, tk, tx);
        check("R7 second edge ignored, sample", sc - e0, 32);
        check("R7 second edge ignored, end", tx - e0, 59);
    endtask

    task automatic t_vote(input string req, input logic tri3, input int hi_off,
                          input int lo_off, input int exp_b);
        int t, e0, sc, tk, tx; logic sb;
        triple_en = tri3;
        wait_tx(t);
        e0 = t + 1;
        run_bit(e0 + 1, 1'b0, e0 + hi_off, 1'b1, (lo_off < 0) ? -1 : e0 + lo_off, 1'b0,
                sc, sb, tk, tx);
        triple_en = 1'b0;
        check({req, " sample cycle"}, sc - e0, 28);
        check({req, " voted bit"}, int'(sb), exp_b);
    endtask

    initial begin
        t_reset();
        t_tick_period();
        t_nominal();
        t_hard_sync();
        t_edge("R5 late edge k=0 ext 1", P + 1, 32, 59);
        t_edge("R5 late edge k=3 clamped to sjw", 4 * P + 2, 36, 63);
        t_edge("R6 early edge q=2 shrink 2", 9 * P + 1, 28, 47);
        t_edge("R6 edge in last BS2 quantum", 13 * P + 1, 28, 55);
        t_edge("R7 edge in SYNC no change", 1, 28, 55);
        t_edge("R8 edge on sample clock", 27, 36, 63);
        t_once_per_bit();
        t_vote("R9 triple 0,0,1", 1'b1, 27, -1, 0);
        t_vote("R9 single 0,0,1", 1'b0, 27, -1, 1);
        t_vote("R9 triple 1,1,0", 1'b1, 25, 27, 1);
        t_vote("R9 single 1,1,0", 1'b0, 25, 27, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual %0d expected 0", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule